// File: doc/BRIEF.md
# Half-Bridge Dead-Time and Drain-Source Blanking Controller

This block sequences the gate enables of a full bridge made of half-bridge phases. Each phase receives a two-bit drive request: high side on, low side on, coast, or high impedance. From it the block derives a high-side and a low-side gate enable. Whenever a conducting switch is released, its partner on the same phase stays off for a programmed dead time. The dead time is an 8-bit base count of clock cycles, multiplied by 1 or by 32 through a scale input.

The block also guards the drain-to-source overvoltage comparators of the external switches. After each change of a phase's request, the comparator result is masked for two dead times. The mask is shortened to one dead time when a phase turns on after a long coast or high-impedance spell, because no dead time precedes such a turn-on. Once the mask has ended, the comparator of a switch that is actually on is watched. When it reports excess voltage on two clocks in a row, the phase raises its motor-fault output.

Top module: `hbdt_top`

## Requirements
- R1: While and right after reset, every gate enable, every check window and every motor-fault output is low, and each phase counts as being in high impedance.
- R2: When a conducting gate is released, the other gate of that phase rises exactly max(D,1) clock cycles after the falling edge, and the two gates of a phase are never high together. D is the effective dead time.
- R3: The effective dead time D equals the base count when the scale input is 0, and 32 times the base count when it is 1.
- R4: The per-phase request is {hi,lo}: 2'b10 requests the high side, 2'b01 the low side, 2'b00 high impedance and 2'b11 coast. Both of the last two drive both gates low.
- R5: A request to turn a gate on, made while both gates are off and no dead time is pending, takes effect on the next clock edge.
- R6: A change of a phase's request at edge t loads a mask of 2·D cycles. The check window of that phase is high only when the mask has run out and one of its gates is on.
- R7: When a phase goes from coast or high impedance to an on request, and the idle request was held for at least 2·D sampled cycles, the mask is D cycles instead of 2·D.
- R8: An idle spell shorter than 2·D sampled cycles before turning on still gives a mask of 2·D cycles.
- R9: A phase's motor-fault output goes high one edge after its check window and an overvoltage on its conducting switch have both been present on two consecutive clock edges. A single-cycle overvoltage does not raise it.
- R10: The overvoltage input of a switch that is off has no effect on the motor-fault output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| long_scale | input | 1 | Dead-time multiplier select: 0 gives x1, 1 gives x32 |
| dead_base | input | 8 | Base dead time in clock cycles |
| phase_cmd | input | 2*NPH | Per-phase request {hi,lo}; phase p uses bits [2p+1:2p] |
| ds_over_hi | input | NPH | High-side drain-source overvoltage, one bit per phase |
| ds_over_lo | input | NPH | Low-side drain-source overvoltage, one bit per phase |
| gate_hi | output | NPH | High-side gate enable |
| gate_lo | output | NPH | Low-side gate enable |
| ds_window | output | NPH | Comparator check window, high when unmasked and a gate is on |
| motor_fault | output | NPH | Filtered motor fault per phase |

## Verification
On every cycle the assertions check that the two gates of a phase are never high together, and that a falling gate is never met by its partner rising on the same edge. They also check that a gate only rises when its side was requested, that the window is shut on the cycle after any request change, and that a fault only follows two edges of window plus overvoltage on the conducting side. Only the bench's scenarios can show the exact dead-time length under both scale settings and the choice between the long and the short mask after idle spells. They also show that a one-cycle overvoltage glitch is rejected, and they compare all outputs cycle by cycle against a behavioural model under random requests.

// File: rtl/hbdt_pkg.sv
// Shared encodings for the half-bridge dead-time controller.
// Assumes two request bits per phase, ordered {hi,lo}.
package hbdt_pkg;
    typedef enum logic [1:0] {
        REQ_HIZ   = 2'b00,
        REQ_LOW   = 2'b01,
        REQ_HIGH  = 2'b10,
        REQ_COAST = 2'b11
    } phase_req_e;

    // True for the two requests that leave both gates off.
    function automatic logic req_idle(input logic [1:0] req);
        return (req == REQ_HIZ) || (req == REQ_COAST);
    endfunction
endpackage

// File: rtl/hbdt_gate_seq.sv
// Gate sequencer for one phase.
// A released gate drops at once. Any new enable then waits until the
// dead-time counter has run out, so the two gates never overlap.
// Assumes dead_cyc is stable except when the user reprograms it.
module hbdt_gate_seq
    import hbdt_pkg::*;
#(
    parameter int DT_W = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      req,
    input  logic [DT_W-1:0] dead_cyc,
    output logic            gh,
    output logic            gl
);
    logic            want_hi;
    logic            want_lo;
    logic            releasing;
    logic [DT_W-1:0] dead_left;

    // Decode the request into the wanted gate states.
    always_comb begin
        want_hi   = (req == REQ_HIGH);
        want_lo   = (req == REQ_LOW);
        releasing = (gh && !want_hi) || (gl && !want_lo);
    end

    // Drop released gates, count the dead time, then apply the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gh        <= 1'b0;
            gl        <= 1'b0;
            dead_left <= '0;
        end else if (releasing) begin
            gh        <= gh && want_hi;
            gl        <= gl && want_lo;
            dead_left <= dead_cyc;
        end else if (dead_left > DT_W'(1)) begin
            dead_left <= dead_left - DT_W'(1);
        end else begin
            dead_left <= '0;
            gh        <= want_hi;
            gl        <= want_lo;
        end
    end
endmodule

// File: rtl/hbdt_blank_win.sv
// Drain-source blanking window for one phase.
// Any change of request loads a mask of two dead times. A turn-on that
// follows an idle request held for at least two dead times loads one.
// The window opens when the mask is spent and a gate is on.
module hbdt_blank_win
    import hbdt_pkg::*;
#(
    parameter int DT_W = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      req,
    input  logic [DT_W-1:0] dead_cyc,
    input  logic            gate_on,
    output logic            window
);
    localparam int BL_W = DT_W + 1;

    logic [1:0]      req_q;
    logic [BL_W-1:0] mask_left;
    logic [BL_W-1:0] idle_len;
    logic [BL_W-1:0] two_dead;
    logic [BL_W-1:0] one_dead;
    logic            changed;
    logic            long_idle;

    // Derive the mask lengths and the change and long-idle conditions.
    always_comb begin
        two_dead  = {dead_cyc, 1'b0};
        one_dead  = {1'b0, dead_cyc};
        changed   = (req != req_q);
        long_idle = req_idle(req_q) && !req_idle(req) && (idle_len >= two_dead);
        window    = (mask_left == '0) && gate_on;
    end

    // Track the last request, the mask countdown and the idle duration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q     <= REQ_HIZ;
            mask_left <= '0;
            idle_len  <= '0;
        end else begin
            req_q <= req;
            if (changed) begin
                mask_left <= long_idle ? one_dead : two_dead;
                idle_len  <= req_idle(req) ? BL_W'(1) : '0;
            end else begin
                if (mask_left != '0) begin
                    mask_left <= mask_left - BL_W'(1);
                end
                if (req_idle(req_q) && (idle_len < two_dead)) begin
                    idle_len <= idle_len + BL_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/hbdt_ds_filter.sv
// Two-sample filter for the drain-source overvoltage of one phase.
// Only the comparator of a conducting switch counts, and only inside
// the window. The fault is high after two consecutive qualifying edges.
module hbdt_ds_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic gh,
    input  logic gl,
    input  logic window,
    input  logic ov_hi,
    input  logic ov_lo,
    output logic fault
);
    logic hit;
    logic hit_q;

    // Qualify the comparator with the window and the conducting side.
    always_comb begin
        hit = window && ((gh && ov_hi) || (gl && ov_lo));
    end

    // Remember the last sample and flag two in a row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
            fault <= 1'b0;
        end else begin
            hit_q <= hit;
            fault <= hit && hit_q;
        end
    end
endmodule

// File: rtl/hbdt_top.sv
// Dead-time and blanking controller for NPH half-bridge phases.
// Scales the base dead time and builds one sequencer, blanking window
// and fault filter per phase. Comparator inputs are assumed to be
// synchronous to clk already.
module hbdt_top
    import hbdt_pkg::*;
#(
    parameter int NPH      = 2,
    parameter int BASE_W   = 8,
    parameter int SCALE_SH = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                long_scale,
    input  logic [BASE_W-1:0]   dead_base,
    input  logic [2*NPH-1:0]    phase_cmd,
    input  logic [NPH-1:0]      ds_over_hi,
    input  logic [NPH-1:0]      ds_over_lo,
    output logic [NPH-1:0]      gate_hi,
    output logic [NPH-1:0]      gate_lo,
    output logic [NPH-1:0]      ds_window,
    output logic [NPH-1:0]      motor_fault
);
    localparam int DT_W = BASE_W + SCALE_SH;

    logic [DT_W-1:0] dead_cyc;

    // Apply the x1 or x32 multiplier to the base count.
    always_comb begin
        dead_cyc = long_scale ? (DT_W'(dead_base) << SCALE_SH) : DT_W'(dead_base);
    end

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        logic [1:0] req;
        assign req = phase_cmd[2*p +: 2];

        hbdt_gate_seq #(.DT_W(DT_W)) u_seq (
            .clk      (clk),
            .rst_n    (rst_n),
            .req      (req),
            .dead_cyc (dead_cyc),
            .gh       (gate_hi[p]),
            .gl       (gate_lo[p])
        );

        hbdt_blank_win #(.DT_W(DT_W)) u_blank (
            .clk      (clk),
            .rst_n    (rst_n),
            .req      (req),
            .dead_cyc (dead_cyc),
            .gate_on  (gate_hi[p] | gate_lo[p]),
            .window   (ds_window[p])
        );

        hbdt_ds_filter u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .gh     (gate_hi[p]),
            .gl     (gate_lo[p]),
            .window (ds_window[p]),
            .ov_hi  (ds_over_hi[p]),
            .ov_lo  (ds_over_lo[p]),
            .fault  (motor_fault[p])
        );
    end
endmodule

// File: rtl/hbdt_chk.sv
// Protocol checker for hbdt_top, attached through bind.
// Observes the top-level ports only.
module hbdt_chk #(
    parameter int NPH    = 2,
    parameter int BASE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [BASE_W-1:0] dead_base,
    input logic [2*NPH-1:0]  phase_cmd,
    input logic [NPH-1:0]    ds_over_hi,
    input logic [NPH-1:0]    ds_over_lo,
    input logic [NPH-1:0]    gate_hi,
    input logic [NPH-1:0]    gate_lo,
    input logic [NPH-1:0]    ds_window,
    input logic [NPH-1:0]    motor_fault
);
    for (genvar p = 0; p < NPH; p++) begin : g_chk
        // R2
        no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(gate_hi[p] && gate_lo[p]));
        // R2
        hi_release_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(gate_hi[p]) |-> !gate_lo[p]);
        // R2
        lo_release_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(gate_lo[p]) |-> !gate_hi[p]);
        // R5
        hi_rise_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_hi[p]) |-> ($past(phase_cmd[2*p +: 2]) == 2'b10));
        // R5
        lo_rise_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_lo[p]) |-> ($past(phase_cmd[2*p +: 2]) == 2'b01));
        // R6
        mask_after_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && (phase_cmd[2*p +: 2] != $past(phase_cmd[2*p +: 2]))
             && (dead_base != '0)) |=> !ds_window[p]);
        // R9
        fault_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
            motor_fault[p] |->
                $past(ds_window[p] && ((gate_hi[p] && ds_over_hi[p]) || (gate_lo[p] && ds_over_lo[p])))
             && $past(ds_window[p] && ((gate_hi[p] && ds_over_hi[p]) || (gate_lo[p] && ds_over_lo[p])), 2));
    end
endmodule

bind hbdt_top hbdt_chk #(.NPH(NPH), .BASE_W(BASE_W)) u_hbdt_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dead_base   (dead_base),
    .phase_cmd   (phase_cmd),
    .ds_over_hi  (ds_over_hi),
    .ds_over_lo  (ds_over_lo),
    .gate_hi     (gate_hi),
    .gate_lo     (gate_lo),
    .ds_window   (ds_window),
    .motor_fault (motor_fault)
);

// File: tb/hbdt_top_test.sv
`timescale 1ns/1ps
// Bench for hbdt_top: behavioural per-cycle model plus directed scenarios.
module hbdt_top_test;
    localparam int NPH = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             long_scale = 1'b0;
    logic [7:0]       dead_base = 8'd3;
    logic [2*NPH-1:0] phase_cmd = '0;
    logic [NPH-1:0]   ds_over_hi = '0;
    logic [NPH-1:0]   ds_over_lo = '0;
    logic [NPH-1:0]   gate_hi, gate_lo, ds_window, motor_fault;

    int n_checks = 0;
    int n_errors = 0;
    bit started = 0;

    hbdt_top uut (
        .clk(clk), .rst_n(rst_n), .long_scale(long_scale), .dead_base(dead_base),
        .phase_cmd(phase_cmd), .ds_over_hi(ds_over_hi), .ds_over_lo(ds_over_lo),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .ds_window(ds_window),
        .motor_fault(motor_fault)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string what, input int got, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s got=%0d exp=%0d at %0t", what, got, exp, $time);
        end
    endtask

    // Behavioural reference model state, one entry per phase.
    int m_gh[NPH], m_gl[NPH], m_dead[NPH], m_last[NPH], m_mask[NPH];
    int m_idle[NPH], m_hitq[NPH], m_flt[NPH];

    function automatic bit is_idle(input int r);
        return (r == 0) || (r == 3);
    endfunction

    always @(posedge clk) begin
        int d;
        d = long_scale ? 32 * int'(dead_base) : int'(dead_base);
        started = 1;
        for (int p = 0; p < NPH; p++) begin
            int r;
            bit win, hit, wh, wl;
            r = int'(phase_cmd[2*p +: 2]);
            if (!rst_n) begin
                m_gh[p] = 0; m_gl[p] = 0; m_dead[p] = 0; m_last[p] = 0;
                m_mask[p] = 0; m_idle[p] = 0; m_hitq[p] = 0; m_flt[p] = 0;
            end else begin
                win = (m_mask[p] == 0) && (m_gh[p] != 0 || m_gl[p] != 0);
                hit = win && ((m_gh[p] != 0 && ds_over_hi[p]) || (m_gl[p] != 0 && ds_over_lo[p]));
                m_flt[p] = (hit && m_hitq[p] != 0) ? 1 : 0;
                m_hitq[p] = hit ? 1 : 0;
                if (r != m_last[p]) begin
                    if (is_idle(m_last[p]) && !is_idle(r) && m_idle[p] >= 2 * d) m_mask[p] = d;
                    else m_mask[p] = 2 * d;
                    m_idle[p] = is_idle(r) ? 1 : 0;
                end else begin
                    if (m_mask[p] > 0) m_mask[p]--;
                    if (is_idle(m_last[p]) && m_idle[p] < 2 * d) m_idle[p]++;
                end
                m_last[p] = r;
                wh = (r == 2); wl = (r == 1);
                if ((m_gh[p] != 0 && !wh) || (m_gl[p] != 0 && !wl)) begin
                    m_gh[p] = (m_gh[p] != 0 && wh) ? 1 : 0;
                    m_gl[p] = (m_gl[p] != 0 && wl) ? 1 : 0;
                    m_dead[p] = d;
                end else if (m_dead[p] > 1) begin
                    m_dead[p]--;
                end else begin
                    m_dead[p] = 0; m_gh[p] = wh; m_gl[p] = wl;
                end
            end
        end
    end

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        if (started) begin
            for (int p = 0; p < NPH; p++) begin
                chk(int'(gate_hi[p]) == m_gh[p], "R2 model gate_hi", int'(gate_hi[p]), m_gh[p]);
                chk(int'(gate_lo[p]) == m_gl[p], "R2 model gate_lo", int'(gate_lo[p]), m_gl[p]);
                chk(int'(ds_window[p]) == ((m_mask[p] == 0 && (m_gh[p] + m_gl[p]) > 0) ? 1 : 0),
                    "R6 model ds_window", int'(ds_window[p]),
                    (m_mask[p] == 0 && (m_gh[p] + m_gl[p]) > 0) ? 1 : 0);
                chk(int'(motor_fault[p]) == m_flt[p], "R9 model motor_fault", int'(motor_fault[p]), m_flt[p]);
            end
        end
    end

    task automatic set_req(input int p, input logic [1:0] r);
        phase_cmd[2*p +: 2] = r;
    endtask

    // After a request change, count falling edges until the window and gate_lo rise.
    task automatic measure(input int p, input int maxc, output int n_win, output int n_lo);
        n_win = -1; n_lo = -1;
        for (int n = 1; n <= maxc; n++) begin
            @(negedge clk);
            if (n_lo < 0 && gate_lo[p]) n_lo = n;
            if (n_win < 0 && ds_window[p]) n_win = n;
        end
    endtask

    task automatic fault_seen(input int p, input int cyc, output bit seen);
        seen = 0;
        for (int n = 0; n < cyc; n++) begin
            @(negedge clk);
            if (motor_fault[p]) seen = 1;
        end
    endtask

    initial begin
        int nw, nl;
        bit seen;
        repeat (4) @(negedge clk);
        // R1: outputs during reset.
        chk(gate_hi == '0 && gate_lo == '0, "R1 gates in reset", int'({gate_hi, gate_lo}), 0);
        chk(ds_window == '0 && motor_fault == '0, "R1 window/fault in reset",
            int'({ds_window, motor_fault}), 0);
        rst_n = 1'b1;
        repeat (12) @(negedge clk);
        chk(gate_hi == '0 && gate_lo == '0, "R1 gates after reset", int'({gate_hi, gate_lo}), 0);

        // R7 and R5: long hi-Z to high, D=3.
        set_req(0, 2'b10);
        @(negedge clk);
        chk(gate_hi[0] == 1'b1, "R5 gate_hi next edge", int'(gate_hi[0]), 1);
        measure(0, 10, nw, nl);
        chk(nw == 3, "R7 long idle mask D", nw + 1, 4);
        // R2 and R6: high to low, dead time 3 then window at 2D.
        set_req(0, 2'b01);
        measure(0, 12, nw, nl);
        chk(nl == 4, "R2 dead gap D=3", nl, 4);
        chk(nw == 7, "R6 mask 2D after change", nw, 7);
        // R4: coast request turns both gates off, then short idle.
        set_req(0, 2'b11);
        @(negedge clk);
        chk(gate_hi[0] == 1'b0 && gate_lo[0] == 1'b0, "R4 coast both low",
            int'({gate_hi[0], gate_lo[0]}), 0);
        @(negedge clk);
        // R8: short coast then high keeps 2D.
        set_req(0, 2'b10);
        measure(0, 12, nw, nl);
        chk(nw == 7, "R8 short idle mask 2D", nw, 7);
        // R3: scale x32 with base 2 gives D=64.
        long_scale = 1'b1; dead_base = 8'd2;
        set_req(0, 2'b01);
        measure(0, 140, nw, nl);
        chk(nl == 65, "R3 scaled dead gap", nl, 65);
        chk(nw == 129, "R3 scaled mask", nw, 129);
        long_scale = 1'b0; dead_base = 8'd3;
        repeat (10) @(negedge clk);

        // Phase 1: long hi-Z to low, then fault filter cases.
        set_req(1, 2'b01);
        measure(1, 8, nw, nl);
        chk(nw == 4, "R7 long hi-Z mask D", nw, 4);
        ds_over_lo[1] = 1'b1;
        @(negedge clk);
        ds_over_lo[1] = 1'b0;
        fault_seen(1, 5, seen);
        chk(!seen, "R9 single glitch rejected", int'(seen), 0);
        ds_over_hi[1] = 1'b1;
        fault_seen(1, 6, seen);
        ds_over_hi[1] = 1'b0;
        chk(!seen, "R10 off side ignored", int'(seen), 0);
        ds_over_lo[1] = 1'b1;
        fault_seen(1, 4, seen);
        ds_over_lo[1] = 1'b0;
        chk(seen, "R9 two samples raise fault", int'(seen), 1);
        // R6: overvoltage held through the mask after low to high.
        ds_over_hi[1] = 1'b1;
        set_req(1, 2'b10);
        fault_seen(1, 7, seen);
        chk(!seen, "R6 masked during blanking", int'(seen), 0);
        fault_seen(1, 4, seen);
        chk(seen, "R9 fault after mask", int'(seen), 1);
        ds_over_hi[1] = 1'b0;

        // Random stretch, compared against the model every cycle.
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 5) == 0) set_req(0, 2'($urandom_range(0, 3)));
            if ($urandom_range(0, 5) == 0) set_req(1, 2'($urandom_range(0, 3)));
            ds_over_hi = NPH'($urandom_range(0, 3));
            ds_over_lo = NPH'($urandom_range(0, 3));
            if (i == 1500) dead_base = 8'd1;
            if (i == 2200) dead_base = 8'd0;
            @(negedge clk);
        end
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule